// File: doc/BRIEF.md
# Posted-CAS Latency Data-Window Scheduler

This block sits on the controller side of a DDR3-style memory interface. Each read or write column command accepted by the controller is turned into an enable that opens a data window on the exact clock at which the memory returns read data or expects write data. The window lasts as long as the command's burst.

The latency of each command comes from three programmed settings: the CAS latency, the CAS write latency and a coded additive-latency select. Read latency is the additive latency plus the CAS latency. Write latency is the additive latency plus the CAS write latency, which is programmed on its own. Up to four commands may be in flight. They are held in an in-order queue, and each one carries a 3-bit bank tag, which is shown while its window is open.

A command whose window would collide with an already scheduled window in the opposite direction is refused and flagged. The latency settings are captured only while nothing is pending, so a reprogramming made mid-stream takes effect once the queue drains.

Top module: `cas_window_sched`

## Requirements
- R1: `cfg_al_sel` selects the additive latency: 2'b00 gives 0, 2'b01 gives CL-1, 2'b10 gives CL-2, and 2'b11 is reserved and behaves as 0.
- R2: A read accepted in cycle n raises `rd_win` first in cycle n+AL+CL.
- R3: A write accepted in cycle n raises `wr_win` first in cycle n+AL+CWL, where CWL is taken from `cfg_cwl` and does not depend on CL.
- R4: A window stays open for 4 consecutive cycles when `cmd_chop` is 0 (burst of 8) and for 2 cycles when `cmd_chop` is 1 (chopped burst of 4).
- R5: While a window is open, `win_bank` shows the bank tag of the oldest command whose window is open in that cycle.
- R6: At most 4 commands are held. `cmd_ready` is low while 4 are held. Commands leave in issue order: a command leaves in the cycle after the later of its own last window cycle and the cycle in which the command ahead of it left.
- R7: A command that is presented while `cmd_ready` is high, and whose window would share a cycle with the window of a held command of the opposite direction, is not accepted. In that case `err_overlap` is high for exactly the next cycle.
- R8: The latency settings are used as they stand in any cycle in which no command is held, and the values from the last such cycle are used while commands are held. A change made while commands are held has no effect on commands accepted before the queue empties.
- R9: After reset, `rd_win`, `wr_win` and `err_overlap` are low and `cmd_ready` is high.
- R10: `rd_win` and `wr_win` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cl | input | CFG_W | CAS latency in clocks (at least 2) |
| cfg_cwl | input | CFG_W | CAS write latency in clocks (at least 1) |
| cfg_al_sel | input | 2 | Additive-latency select code |
| cmd_valid | input | 1 | A column command is presented |
| cmd_ready | output | 1 | The queue has room for a command |
| cmd_wr | input | 1 | 1 for a write, 0 for a read |
| cmd_bank | input | 3 | Target bank of the command |
| cmd_chop | input | 1 | 1 for a chopped 4-beat burst, 0 for 8 beats |
| rd_win | output | 1 | Read-capture window enable |
| wr_win | output | 1 | Write-drive window enable |
| win_bank | output | 3 | Bank of the oldest open window |
| err_overlap | output | 1 | One-cycle flag for a refused opposite-direction collision |

## Verification
The hardest case to reach is a change to the latency settings that arrives while the queue is still busy, followed by another command that must still use the old latency. A directed sequence programs CL=6, issues a read, changes CL to 10 on the next cycle and issues a second read four cycles later. The two windows must then sit back to back with no gap. The random phase also changes the settings at random cycles and relies on a bench model that latches latencies only in empty cycles. Opposite-direction collisions and a full queue are forced with short read-then-write pairs and with bursts of reads at a long latency.

// File: rtl/cws_pkg.sv
// Package: shared widths, encodings and slot type for the data-window scheduler.
// Assumes CAS settings fit in LAT_W-1 bits.
package cws_pkg;
    localparam int BANK_W   = 3;
    localparam int LAT_W    = 8;
    localparam int LEN_W    = 3;
    localparam int BL8_CLKS = 4;
    localparam int BC4_CLKS = 2;

    typedef enum logic [1:0] {
        AL_NONE  = 2'b00,
        AL_CL_M1 = 2'b01,
        AL_CL_M2 = 2'b10,
        AL_RSVD  = 2'b11
    } al_code_e;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [LAT_W-1:0]  dly;
        logic [LEN_W-1:0]  len;
    } slot_t;

    // Advance one slot by one clock: count down the delay, then the window length.
    function automatic slot_t slot_tick(input slot_t s);
        slot_t r;
        r = s;
        if (s.dly != '0)
            r.dly = s.dly - 1'b1;
        else if (s.len != '0)
            r.len = s.len - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cws_lat_sel.sv
// Latency selector: forms read and write latency from CL, CWL and the
// additive-latency code. It holds the values captured in the last idle cycle
// while commands are pending. Assumes CL >= 2 so CL-2 does not wrap.
module cws_lat_sel
    import cws_pkg::*;
#(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic [CFG_W-1:0] cl,
    input  logic [CFG_W-1:0] cwl,
    input  logic [1:0]       al_sel,
    output logic [LAT_W-1:0] rd_lat,
    output logic [LAT_W-1:0] wr_lat
);
    logic [LAT_W-1:0] al_now, rd_now, wr_now, rd_q, wr_q;

    // Decode the additive-latency code against the present CL.
    always_comb begin
        unique case (al_code_e'(al_sel))
            AL_CL_M1: al_now = LAT_W'(cl) - LAT_W'(1);
            AL_CL_M2: al_now = LAT_W'(cl) - LAT_W'(2);
            default:  al_now = '0;
        endcase
        rd_now = al_now + LAT_W'(cl);
        wr_now = al_now + LAT_W'(cwl);
    end

    // Capture the settings on every idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (idle) begin
            rd_q <= rd_now;
            wr_q <= wr_now;
        end
    end

    // Idle cycles see live settings, busy cycles see the captured ones.
    always_comb begin
        rd_lat = idle ? rd_now : rd_q;
        wr_lat = idle ? wr_now : wr_q;
    end

    // R8: latencies cannot move while commands stay pending.
    p_lat_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable({rd_lat, wr_lat}));
endmodule

// File: rtl/cws_overlap_chk.sv
// Collision check: tests whether a new command's window shares any cycle with
// a pending window of the opposite direction. Offsets are in cycles from now.
// Assumes held slots obey the delay-then-length countdown of slot_tick.
module cws_overlap_chk
    import cws_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_t [DEPTH-1:0] slots,
    input  logic             new_wr,
    input  logic [LAT_W-1:0] new_lat,
    input  logic [LEN_W-1:0] new_len,
    output logic             clash
);
    localparam int SUM_W = LAT_W + 1;

    logic [DEPTH-1:0] hit;
    logic [SUM_W-1:0] new_end;

    // End offset (exclusive) of the new window.
    always_comb new_end = SUM_W'(new_lat) + SUM_W'(new_len);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [SUM_W-1:0] old_end;
        // Interval test between slot i and the new window.
        always_comb begin
            old_end = SUM_W'(slots[i].dly) + SUM_W'(slots[i].len);
            hit[i]  = slots[i].vld && (slots[i].wr != new_wr) &&
                      (slots[i].len != '0) &&
                      (SUM_W'(new_lat) < old_end) &&
                      (SUM_W'(slots[i].dly) < new_end);
        end
    end

    // Any hit flags the collision.
    always_comb clash = |hit;

    // R7: a collision needs at least one live window in the queue.
    p_clash_needs_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> ($countones(hit) >= 1 && slots[0].vld));
endmodule

// File: rtl/cws_slot_queue.sv
// In-order slot queue: holds pending commands with their delay and window
// countdowns, frees the head once its window is over, and decodes the open
// windows and the oldest open bank. Assumes push only when count < DEPTH.
module cws_slot_queue
    import cws_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  slot_t                   push_slot,
    output slot_t [DEPTH-1:0]       slots,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                    rd_win,
    output logic                    wr_win,
    output logic [BANK_W-1:0]       win_bank
);
    localparam int CNT_W = $clog2(DEPTH+1);

    slot_t [DEPTH-1:0] slots_q, slots_d;
    logic [CNT_W-1:0]  count_q, load_idx;
    logic              head_done;
    logic [DEPTH-1:0]  live_rd, live_wr;

    // Head leaves once its window reaches its last cycle (or is already spent).
    always_comb begin
        head_done = slots_q[0].vld && (slots_q[0].dly == '0) &&
                    (slots_q[0].len <= LEN_W'(1));
        load_idx  = count_q - CNT_W'(head_done);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t src, nxt;
        // Pick the slot's source (shift on head exit) and advance it one clock.
        always_comb begin
            if (head_done) begin
                if (i == DEPTH - 1) src = '0;
                else                src = slots_q[(i + 1) % DEPTH];
            end else begin
                src = slots_q[i];
            end
            nxt = src.vld ? slot_tick(src) : '0;
            if (push && (load_idx == CNT_W'(i)))
                nxt = push_slot;
        end
        assign slots_d[i] = nxt;
        // Per-slot open-window flags by direction.
        always_comb begin
            live_rd[i] = slots_q[i].vld && (slots_q[i].dly == '0) &&
                         (slots_q[i].len != '0) && !slots_q[i].wr;
            live_wr[i] = slots_q[i].vld && (slots_q[i].dly == '0) &&
                         (slots_q[i].len != '0) && slots_q[i].wr;
        end
    end

    // Register the queue contents and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            count_q <= '0;
        end else begin
            slots_q <= slots_d;
            count_q <= count_q + CNT_W'(push) - CNT_W'(head_done);
        end
    end

    // Window enables and the bank of the oldest open window.
    always_comb begin
        rd_win   = |live_rd;
        wr_win   = |live_wr;
        win_bank = '0;
        for (int k = DEPTH - 1; k >= 0; k--)
            if (live_rd[k] || live_wr[k]) win_bank = slots_q[k].bank;
    end

    assign slots = slots_q;
    assign count = count_q;

    // R6: occupancy never exceeds the queue depth.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    // R6: a push only arrives when a slot is free.
    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q < CNT_W'(DEPTH)));
    // R10: opposite windows never coincide.
    p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_win && wr_win));
    // R4: a window that opens is open at least two cycles.
    p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_win) |=> rd_win);
endmodule

// File: rtl/cas_window_sched.sv
// Top: posted-CAS data-window scheduler. It accepts column commands, picks the
// read or write latency, refuses opposite-direction window collisions, and
// drives the read-capture and write-drive windows from an in-order queue.
// Assumes CL >= 2, CWL >= 1 and CFG_W + 1 <= LAT_W.
module cas_window_sched
    import cws_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CFG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_cwl,
    input  logic [1:0]        cfg_al_sel,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_wr,
    input  logic [2:0]        cmd_bank,
    input  logic              cmd_chop,
    output logic              rd_win,
    output logic              wr_win,
    output logic [2:0]        win_bank,
    output logic              err_overlap
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [CNT_W-1:0]  count;
    logic              idle, clash, accept, err_q;
    logic [LAT_W-1:0]  rd_lat, wr_lat, sel_lat;
    logic [LEN_W-1:0]  new_len;
    slot_t             new_slot;
    slot_t [DEPTH-1:0] slots;

    // Idle and room decode from the occupancy.
    always_comb begin
        idle      = (count == '0);
        cmd_ready = (count < CNT_W'(DEPTH));
    end

    cws_lat_sel #(.CFG_W(CFG_W)) lat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .cl     (cfg_cl),
        .cwl    (cfg_cwl),
        .al_sel (cfg_al_sel),
        .rd_lat (rd_lat),
        .wr_lat (wr_lat)
    );

    // Build the candidate slot for the presented command.
    always_comb begin
        sel_lat       = cmd_wr ? wr_lat : rd_lat;
        new_len       = cmd_chop ? LEN_W'(BC4_CLKS) : LEN_W'(BL8_CLKS);
        new_slot.vld  = 1'b1;
        new_slot.wr   = cmd_wr;
        new_slot.bank = cmd_bank;
        new_slot.dly  = sel_lat - LAT_W'(1);
        new_slot.len  = new_len;
    end

    cws_overlap_chk #(.DEPTH(DEPTH)) chk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .slots   (slots),
        .new_wr  (cmd_wr),
        .new_lat (sel_lat),
        .new_len (new_len),
        .clash   (clash)
    );

    // Accept only with room and without a collision.
    always_comb accept = cmd_valid && cmd_ready && !clash;

    cws_slot_queue #(.DEPTH(DEPTH)) q_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_slot (new_slot),
        .slots     (slots),
        .count     (count),
        .rd_win    (rd_win),
        .wr_win    (wr_win),
        .win_bank  (win_bank)
    );

    // Flag a refused collision for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= cmd_valid && cmd_ready && clash;
    end
    assign err_overlap = err_q;

    // R7: the flag follows a presented command by one cycle.
    p_err_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |-> $past(cmd_valid));
    // R7: a refused command leaves the occupancy unchanged.
    p_refused_no_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |-> (count <= $past(count)));
    // R9: windows need a pending command.
    p_win_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win || wr_win) |-> !idle);
endmodule

// File: tb/cas_window_sched_tb_top.sv
module cas_window_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_cl = 5'd7, cfg_cwl = 5'd6;
    logic [1:0] cfg_al_sel = 2'd0;
    logic       cmd_valid = 1'b0, cmd_wr = 1'b0, cmd_chop = 1'b0;
    logic [2:0] cmd_bank = 3'd0;
    logic       cmd_ready, rd_win, wr_win, err_overlap;
    logic [2:0] win_bank;

    always #2 clk = ~clk;   // 250 MHz

    cas_window_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
        .cfg_al_sel(cfg_al_sel), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_chop(cmd_chop),
        .rd_win(rd_win), .wr_win(wr_win), .win_bank(win_bank),
        .err_overlap(err_overlap)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int b_cl = 7, b_cwl = 6, b_sel = 0;
    int lat_rd_l = 0, lat_wr_l = 0, r_last = 0, n_acc = 0;
    int acc_c[8], r_c[8], s_c[8], e_c[8];
    bit wr_c[8];
    bit ex_rd[256], ex_wr[256];
    int ex_bank[256];
    bit ex_err_cur = 0, ex_err_nxt = 0;
    bit obs_rd, obs_wr, obs_ready, obs_err;

    function automatic int lat_of(int cl, int cwl, int sel, bit wr);
        int al;
        al = (sel == 1) ? cl - 1 : (sel == 2) ? cl - 2 : 0;
        return al + (wr ? cwl : cl);
    endfunction

    function automatic int count_at(int m);
        int c = 0;
        for (int k = 0; k < 8; k++)
            if (acc_c[k] < m && r_c[k] > m) c++;
        return c;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
        end
    endtask

    // One cycle: check outputs against the model, then drive and predict.
    task automatic step(bit v, bit w, int b, bit ch);
        int cnt, L, D, s, e, idx, slot;
        bit conf;
        @(negedge clk);
        idx = cyc % 256;
        cnt = count_at(cyc);
        obs_rd = rd_win; obs_wr = wr_win; obs_ready = cmd_ready; obs_err = err_overlap;
        chk("R6", "cmd_ready", cmd_ready, cnt < 4);
        chk("R2", "rd_win", rd_win, ex_rd[idx]);
        chk("R3", "wr_win", wr_win, ex_wr[idx]);
        if (ex_rd[idx] || ex_wr[idx]) chk("R5", "win_bank", win_bank, ex_bank[idx]);
        chk("R7", "err_overlap", err_overlap, ex_err_cur);
        chk("R10", "both windows", rd_win && wr_win, 0);
        ex_rd[idx] = 0; ex_wr[idx] = 0;
        cfg_cl = 5'(b_cl); cfg_cwl = 5'(b_cwl); cfg_al_sel = 2'(b_sel);
        if (cnt == 0) begin
            lat_rd_l = lat_of(b_cl, b_cwl, b_sel, 0);
            lat_wr_l = lat_of(b_cl, b_cwl, b_sel, 1);
        end
        cmd_valid = v; cmd_wr = w; cmd_bank = 3'(b); cmd_chop = ch;
        conf = 0;
        if (v && cnt < 4) begin
            L = w ? lat_wr_l : lat_rd_l;
            D = ch ? 2 : 4;
            s = cyc + L; e = s + D - 1;
            for (int k = 0; k < 8; k++)
                if (acc_c[k] < cyc && r_c[k] > cyc && wr_c[k] != w && s <= e_c[k] && s_c[k] <= e)
                    conf = 1;
            if (!conf) begin
                slot = n_acc % 8; n_acc++;
                acc_c[slot] = cyc; s_c[slot] = s; e_c[slot] = e; wr_c[slot] = w;
                r_c[slot] = ((e > r_last) ? e : r_last) + 1;
                r_last = r_c[slot];
                for (int t = s; t <= e; t++) begin
                    if (!ex_rd[t % 256] && !ex_wr[t % 256]) ex_bank[t % 256] = b;
                    if (w) ex_wr[t % 256] = 1; else ex_rd[t % 256] = 1;
                end
            end
        end
        ex_err_nxt = v && cnt < 4 && conf;
        @(posedge clk);
        cyc++;
        ex_err_cur = ex_err_nxt;
    endtask

    task automatic idle_n(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0);
    endtask

    task automatic measure(bit w, bit ch, output int first, output int width);
        step(1, w, 5, ch);
        first = -1; width = 0;
        for (int k = 1; k <= 40; k++) begin
            step(0, 0, 0, 0);
            if (w ? obs_wr : obs_rd) begin
                if (first < 0) first = k;
                width++;
            end
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        int f, wd, hi_k6, hi_k10, wr_seen;
        void'($urandom(32'd20251));
        for (int k = 0; k < 8; k++) begin acc_c[k] = -1; r_c[k] = 0; s_c[k] = 0; e_c[k] = 0; wr_c[k] = 0; end
        for (int k = 0; k < 256; k++) begin ex_rd[k] = 0; ex_wr[k] = 0; ex_bank[k] = 0; end
        repeat (3) @(negedge clk);
        chk("R9", "ready in reset", cmd_ready, 1);
        chk("R9", "rd_win in reset", rd_win, 0);
        chk("R9", "wr_win in reset", wr_win, 0);
        chk("R9", "err in reset", err_overlap, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);

        // R1 / R2: read latency for each additive-latency code, BL8 width (R4).
        for (int s = 0; s < 4; s++) begin
            b_cl = 7; b_cwl = 6; b_sel = s;
            measure(0, 0, f, wd);
            chk("R1", "read latency for AL code", f, lat_of(7, 6, s, 0));
            chk("R4", "BL8 read width", wd, 4);
        end
        b_sel = 0; measure(0, 0, f, wd);
        chk("R2", "read latency with AL 0", f, 7);

        // R3: write latency from CWL.
        b_sel = 1; measure(1, 0, f, wd);
        chk("R3", "write latency AL+CWL", f, 12);
        // R4: chopped bursts.
        measure(0, 1, f, wd); chk("R4", "chopped read width", wd, 2);
        measure(1, 1, f, wd); chk("R4", "chopped write width", wd, 2);

        // R6: fifth command finds the queue full.
        b_cl = 11; b_sel = 1;
        for (int k = 0; k < 4; k++) begin step(1, 0, k, 0); idle_n(3); end
        step(1, 0, 4, 0);
        chk("R6", "ready with four held", obs_ready, 0);
        idle_n(50);

        // R7: read then overlapping write is refused.
        b_cl = 6; b_cwl = 5; b_sel = 0;
        step(1, 0, 2, 0); step(1, 1, 3, 0); step(0, 0, 0, 0);
        chk("R7", "collision flag", obs_err, 1);
        wr_seen = 0;
        for (int k = 0; k < 30; k++) begin step(0, 0, 0, 0); if (obs_wr) wr_seen++; end
        chk("R7", "refused write window cycles", wr_seen, 0);

        // R8: CL change while busy is not used.
        b_cl = 6; b_sel = 0;
        step(1, 0, 1, 0);
        b_cl = 10;
        idle_n(3);
        step(1, 0, 6, 0);
        hi_k6 = 0; hi_k10 = 0;
        for (int k = 1; k <= 12; k++) begin
            step(0, 0, 0, 0);
            if (k == 6) hi_k6 = obs_rd;
            if (k == 10) hi_k10 = obs_rd;
        end
        chk("R8", "second read keeps old latency", hi_k6, 1);
        chk("R8", "no window at new latency", hi_k10, 0);
        idle_n(30);

        // Random mix with mid-stream reprogramming.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 50 == 0) begin
                b_cl = 5 + int'($urandom % 7);
                b_cwl = 5 + int'($urandom % 5);
                b_sel = int'($urandom % 4);
            end
            step(($urandom % 100) < 35, $urandom % 2, int'($urandom % 8), $urandom % 2);
        end
        idle_n(40);
        summary();
        $finish;
    end
endmodule